// File: doc/BRIEF.md
# Addressed Dual-Bank PWM Array

This block drives sixteen pulse-width-modulated outputs, organised as bank A and bank B with eight channels each. Every channel holds a 10-bit duty value. A single write cycle carries one 3-bit channel index and two 10-bit duty values. The first value goes into that channel of bank A and the second into the same channel of bank B, so one write updates a matching pair of channels.

All sixteen channels compare one shared 10-bit time base against their own duty value, so they stay phase-aligned. The time base does not step on every clock. It advances once every R clocks, where R is a 4-bit ratio code plus one, which gives division by 1 to 16. A shutdown input forces every output low while it is held. Outputs are registered, and the block is meant to sit behind a serial loader that presents one decoded write per cycle.

Top module: `dual_bank_pwm`

## Requirements
- R1: While reset is high, every output is low, every duty value is cleared to 0 and the time base is held at 0. On the first clock after reset is released, every output goes high, because a count of 0 does not exceed a duty of 0.
- R2: A clock edge with `wr_en` high loads `wr_duty_a` into channel `wr_addr` of bank A and `wr_duty_b` into channel `wr_addr` of bank B. All other channels keep their values. The new duty first shows on the outputs one clock after the write edge.
- R3: A clock edge with `wr_en` low changes no duty value, whatever `wr_addr`, `wr_duty_a` and `wr_duty_b` carry.
- R4: An output is high exactly when the time base value in the previous cycle was less than or equal to that channel's duty value and shutdown was low. A duty of 1023 keeps the output high on every cycle. A duty of 0 makes it high only while the count is 0.
- R5: With ratio code `div_code` = c held constant since reset, the time base advances by one every c+1 clocks. After reset the first step comes after c+1 edges, so before edge e (counted from 1 after reset) the count is floor((e-1)/(c+1)) mod 1024.
- R6: The time base wraps from 1023 to 0 and is shared by all sixteen channels.
- R7: While `shutdown` is high, all sixteen outputs are low from the next clock on. Normal PWM output resumes one clock after `shutdown` falls, and the duty values and time base are not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Duty write strobe |
| wr_addr | input | 3 | Channel index written in both banks |
| wr_duty_a | input | 10 | Duty value for the addressed bank A channel |
| wr_duty_b | input | 10 | Duty value for the addressed bank B channel |
| div_code | input | 4 | Time base ratio code, divide by code+1 |
| shutdown | input | 1 | Forces all outputs low |
| pwm_a | output | 8 | Bank A outputs |
| pwm_b | output | 8 | Bank B outputs |

## Verification
The step-spacing assertion assumes that `div_code` is changed only while reset is held, so the gap between two time base steps always equals the current code. The bench respects this by applying each ratio code under reset and keeping it fixed for the whole run that follows. The other properties assume nothing about the inputs beyond reset being synchronous. The stimulus includes a disabled write and a shutdown window in the middle of a run, so the output comparison relies on the duty values and time base surviving both.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int CH_PER_BANK = 8;
  localparam int DUTY_BITS   = 10;
  localparam int RATIO_BITS  = 4;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int RATIO_BITS = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [RATIO_BITS-1:0] div_code,
  output logic                  tick
);
  logic [RATIO_BITS-1:0] phase;
  logic                  at_end;

  // A code lowered below the current phase also ends the period.
  assign at_end = (phase >= div_code);
  assign tick   = at_end;

  always_ff @(posedge clk) begin
    if (rst)         phase <= '0;
    else if (at_end) phase <= '0;
    else             phase <= phase + 1'b1;
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int DUTY_BITS = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  output logic [DUTY_BITS-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (tick) count <= count + 1'b1;
  end
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank #(
  parameter int CH        = 8,
  parameter int DUTY_BITS = 10,
  localparam int AW       = (CH > 1) ? $clog2(CH) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [AW-1:0]                 wr_addr,
  input  logic [DUTY_BITS-1:0]          wr_data,
  input  logic [DUTY_BITS-1:0]          count,
  input  logic                          shutdown,
  output logic [CH-1:0]                 pwm,
  output logic [CH-1:0][DUTY_BITS-1:0]  duty
);
  for (genvar i = 0; i < CH; i++) begin : g_ch
    logic sel;
    assign sel = wr_en && (wr_addr == AW'(i));

    always_ff @(posedge clk) begin
      if (rst)      duty[i] <= '0;
      else if (sel) duty[i] <= wr_data;
    end

    always_ff @(posedge clk) begin
      if (rst) pwm[i] <= 1'b0;
      else     pwm[i] <= !shutdown && (count <= duty[i]);
    end
  end
endmodule

// File: rtl/dual_bank_pwm.sv
module dual_bank_pwm #(
  parameter int CH         = pwm_pkg::CH_PER_BANK,
  parameter int DUTY_BITS  = pwm_pkg::DUTY_BITS,
  parameter int RATIO_BITS = pwm_pkg::RATIO_BITS,
  localparam int AW        = (CH > 1) ? $clog2(CH) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [DUTY_BITS-1:0]  wr_duty_a,
  input  logic [DUTY_BITS-1:0]  wr_duty_b,
  input  logic [RATIO_BITS-1:0] div_code,
  input  logic                  shutdown,
  output logic [CH-1:0]         pwm_a,
  output logic [CH-1:0]         pwm_b
);
  logic                         tick;
  logic [DUTY_BITS-1:0]         count;
  logic [CH-1:0][DUTY_BITS-1:0] duty_a;
  logic [CH-1:0][DUTY_BITS-1:0] duty_b;

  pwm_prescaler #(.RATIO_BITS(RATIO_BITS)) u_pre (
    .clk(clk), .rst(rst), .div_code(div_code), .tick(tick)
  );

  pwm_timebase #(.DUTY_BITS(DUTY_BITS)) u_tb (
    .clk(clk), .rst(rst), .tick(tick), .count(count)
  );

  pwm_bank #(.CH(CH), .DUTY_BITS(DUTY_BITS)) u_bank_a (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_duty_a), .count(count), .shutdown(shutdown),
    .pwm(pwm_a), .duty(duty_a)
  );

  pwm_bank #(.CH(CH), .DUTY_BITS(DUTY_BITS)) u_bank_b (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_duty_b), .count(count), .shutdown(shutdown),
    .pwm(pwm_b), .duty(duty_b)
  );
endmodule

// File: rtl/pwm_checker.sv
module pwm_checker #(
  parameter int CH         = 8,
  parameter int DUTY_BITS  = 10,
  parameter int RATIO_BITS = 4,
  localparam int AW        = (CH > 1) ? $clog2(CH) : 1
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         wr_en,
  input logic [AW-1:0]                wr_addr,
  input logic [DUTY_BITS-1:0]         wr_duty_a,
  input logic [DUTY_BITS-1:0]         wr_duty_b,
  input logic [RATIO_BITS-1:0]        div_code,
  input logic                         shutdown,
  input logic                         tick,
  input logic [DUTY_BITS-1:0]         count,
  input logic [CH-1:0][DUTY_BITS-1:0] duty_a,
  input logic [CH-1:0][DUTY_BITS-1:0] duty_b,
  input logic [CH-1:0]                pwm_a,
  input logic [CH-1:0]                pwm_b
);
  logic [RATIO_BITS-1:0] gap;
  always_ff @(posedge clk) begin
    if (rst)       gap <= '0;
    else if (tick) gap <= '0;
    else           gap <= gap + 1'b1;
  end

  p_tick_gap_r5: assert property (@(posedge clk) disable iff (rst)
    tick |-> (gap == div_code));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count));

  p_step_r6: assert property (@(posedge clk) disable iff (rst)
    (tick && count != {DUTY_BITS{1'b1}}) |=> (count == $past(count) + 1'b1));

  p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (tick && count == {DUTY_BITS{1'b1}}) |=> (count == '0));

  p_write_a_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (duty_a[$past(wr_addr)] == $past(wr_duty_a)));

  p_write_b_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (duty_b[$past(wr_addr)] == $past(wr_duty_b)));

  p_no_write_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(duty_a) && $stable(duty_b)));

  p_shut_r7: assert property (@(posedge clk) disable iff (rst)
    shutdown |=> (pwm_a == '0 && pwm_b == '0));

  for (genvar i = 0; i < CH; i++) begin : g_ch
    p_off_a_r4: assert property (@(posedge clk) disable iff (rst)
      (count > duty_a[i]) |=> !pwm_a[i]);
    p_off_b_r4: assert property (@(posedge clk) disable iff (rst)
      (count > duty_b[i]) |=> !pwm_b[i]);
    p_full_a_r4: assert property (@(posedge clk) disable iff (rst)
      (!shutdown && duty_a[i] == {DUTY_BITS{1'b1}}) |=> pwm_a[i]);
    p_full_b_r4: assert property (@(posedge clk) disable iff (rst)
      (!shutdown && duty_b[i] == {DUTY_BITS{1'b1}}) |=> pwm_b[i]);
  end
endmodule

bind dual_bank_pwm pwm_checker #(
  .CH(CH), .DUTY_BITS(DUTY_BITS), .RATIO_BITS(RATIO_BITS)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_duty_a(wr_duty_a), .wr_duty_b(wr_duty_b), .div_code(div_code),
  .shutdown(shutdown), .tick(tick), .count(count),
  .duty_a(duty_a), .duty_b(duty_b), .pwm_a(pwm_a), .pwm_b(pwm_b)
);

// File: tb/sim_dual_bank_pwm.sv
`timescale 1ns/1ps
module sim_dual_bank_pwm;
  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [9:0] wr_duty_a, wr_duty_b;
  logic [3:0] div_code;
  logic       shutdown;
  logic [7:0] pwm_a, pwm_b;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  dual_bank_pwm u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_duty_a(wr_duty_a), .wr_duty_b(wr_duty_b), .div_code(div_code),
    .shutdown(shutdown), .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  int  ma [8];
  int  mb [8];
  bit  p_en;
  int  p_addr, p_a, p_b;
  bit  sd_m;

  function automatic int pat_a(int i, int d);
    if (i == 0) return 0;
    if (i == 7) return 1023;
    return (i * 131 + d * 37) % 1024;
  endfunction

  task automatic check(string tag, int e, logic [7:0] ea, logic [7:0] eb);
    checks++;
    if (pwm_a !== ea || pwm_b !== eb) begin
      errors++;
      $display("FAIL %s edge %0d: a=%b b=%b expected a=%b b=%b",
               tag, e, pwm_a, pwm_b, ea, eb);
    end
  endtask

  task automatic run(int d, int n_edges, int sd_start, int sd_len);
    int r;
    r = d + 1;
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_duty_a = '0; wr_duty_b = '0;
    shutdown = 1'b0; div_code = 4'(d);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", 0, 8'h00, 8'h00);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) begin ma[i] = 0; mb[i] = 0; end
    p_en = 1'b0; sd_m = 1'b0;
    for (int e = 1; e <= n_edges; e++) begin
      logic [7:0] ea, eb;
      int cb;
      string tag;
      @(posedge clk);
      @(negedge clk);
      cb = ((e - 1) / r) % 1024;
      for (int i = 0; i < 8; i++) begin
        ea[i] = !sd_m && (cb <= ma[i]);
        eb[i] = !sd_m && (cb <= mb[i]);
      end
      if (e == 1)       tag = "R1";
      else if (sd_m)    tag = "R7";
      else if (e <= 12) tag = "R2 R3";
      else              tag = "R4 R5 R6";
      check(tag, e, ea, eb);
      if (p_en) begin ma[p_addr] = p_a; mb[p_addr] = p_b; end
      sd_m = (e >= sd_start) && (e < sd_start + sd_len);
      shutdown = sd_m;
      p_en = 1'b0;
      wr_en = 1'b0;
      if (e <= 8) begin
        p_en = 1'b1; p_addr = e - 1;
        p_a = pat_a(e - 1, d); p_b = 1023 - pat_a(e - 1, d);
        wr_en = 1'b1; wr_addr = 3'(p_addr);
        wr_duty_a = 10'(p_a); wr_duty_b = 10'(p_b);
      end else if (e == 9) begin
        // R3: disabled write with junk data must change nothing
        wr_addr = 3'd3; wr_duty_a = 10'h3FF; wr_duty_b = 10'h000;
      end
    end
  endtask

  initial begin
    run(0, 1100, 400, 20);
    run(1, 2100, 0, 0);
    run(2, 3100, 500, 17);
    run(7, 1000, 0, 0);
    run(15, 16500, 9000, 40);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1900000;
    errors++;
    checks++;
    $display("FAIL watchdog: expected=finished actual=hung");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule